// File: doc/BRIEF.md
# Interrupt Control Register with Set/Clear Mask

This block gathers five internal peripheral events into one interrupt request for a processor. The events are a timer A underflow, a timer B underflow, a time-of-day alarm, a completed serial-port byte, and an edge on an external flag pin. Each one arrives as a single-cycle pulse and is latched into its own flag bit. A per-source enable mask decides which flags may pull the shared, active-low, level-sensitive request line low.

The processor reaches the block through one register on a simple bus with a chip select, a read strobe, a write strobe and 8-bit data. A write changes only the mask bits whose data bits are 1. Data bit 7 chooses between setting those bits and clearing them, so one source can be switched without a read-modify-write. A read returns the latched flags and a summary bit, and it acknowledges every flag it reports. Events keep latching while the processor ignores interrupts. A flag that was never acknowledged raises the request again as soon as its mask bit is set.

The register bus is a control port, not a data stream. It has no valid/ready handshake and no back-pressure. Every access completes in the cycle it is presented. Read data is valid in the same cycle as the strobe, and all state changes take effect at the next rising clock edge.

Top module: `icr_top`

## Requirements
- R1: After reset the mask and all flags are 0, `irq_n` is 1, and a read returns 0x00.
- R2: A one-cycle pulse on `src_evt[i]` sets flag i. The flag reads back at data bit i, with bit 0 = timer A, bit 1 = timer B, bit 2 = time-of-day alarm, bit 3 = serial byte complete and bit 4 = external flag.
- R3: A selected write (`bus_cs` and `bus_wr` high) sets mask bit i when data bit 7 is 1 and data bit i is 1. It clears mask bit i when data bit 7 is 0 and data bit i is 1. Mask bits whose data bit is 0 keep their value.
- R4: Writing 0x7F disables every source. Writing 0x83 enables timer A and timer B. Writing 0x03 disables those two again.
- R5: Read data bits 4..0 are the flags, and bits 6..5 are always 0. Bit 7 is 1 exactly when some flag is pending with its mask bit set.
- R6: A selected read clears all flags at the next clock edge. If no event arrives in that cycle, `irq_n` returns to 1 after that edge.
- R7: An event sets its flag even while its mask bit is 0, and `irq_n` stays 1 in that case. Setting the mask bit while the flag is pending drives `irq_n` to 0 in the cycle after the write edge.
- R8: `irq_n` is a level output. It stays 0 for as long as an enabled flag is pending and no read acknowledges it.
- R9: An event pulse in the same cycle as a read is not lost. Its flag is 1 after the read edge, and the next read reports it.
- R10: A write or read strobe without `bus_cs` has no effect on the mask or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Register select |
| bus_rd | input | 1 | Read strobe; acknowledges flags when selected |
| bus_wr | input | 1 | Write strobe; updates mask when selected |
| bus_wdata | input | DW (8) | Write data; bit DW-1 selects set (1) or clear (0) |
| bus_rdata | output | DW (8) | Read data: summary bit, zero padding, flags; 0 when not reading |
| src_evt | input | NSRC (5) | One-cycle event pulses, one per source |
| irq_n | output | 1 | Active-low level interrupt request |

## Verification
The bench builds the block with the default values, NSRC = 5 and DW = 8. With these values each of the five sources can be pulsed and read back at its own bit position. The two padding bits between the flags and the summary bit exist, so their zero value can be observed. The same widths let the bench apply the literal writes 0x7F, 0x83 and 0x03, and the collisions between an event and a read.

// File: rtl/icr_pkg.sv
package icr_pkg;
  // Default geometry of the interrupt control register
  localparam int unsigned ICR_NSRC = 5;
  localparam int unsigned ICR_DW   = 8;

  // Source bit positions; software decodes these
  localparam int unsigned SRC_TMR_A  = 0;
  localparam int unsigned SRC_TMR_B  = 1;
  localparam int unsigned SRC_ALARM  = 2;
  localparam int unsigned SRC_SERIAL = 3;
  localparam int unsigned SRC_EXTPIN = 4;

  typedef enum logic {
    MASK_CLEAR = 1'b0,
    MASK_SET   = 1'b1
  } mask_op_e;
endpackage

// File: rtl/icr_mask_reg.sv
module icr_mask_reg
  import icr_pkg::*;
#(
  parameter int unsigned NSRC = ICR_NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_en,
  input  mask_op_e        upd_op,
  input  logic [NSRC-1:0] upd_sel,
  output logic [NSRC-1:0] mask_q
);
  // Each mask bit moves only when it is selected
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[i] <= 1'b0;
      end else if (upd_en && upd_sel[i]) begin
        mask_q[i] <= (upd_op == MASK_SET);
      end
    end
  end
endmodule

// File: rtl/icr_flag_bank.sv
module icr_flag_bank #(
  parameter int unsigned NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack,
  input  logic [NSRC-1:0] evt,
  output logic [NSRC-1:0] flag_q
);
  // A new event outranks the acknowledge, so a colliding pulse survives
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
      end else if (evt[i]) begin
        flag_q[i] <= 1'b1;
      end else if (ack) begin
        flag_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/icr_status.sv
module icr_status #(
  parameter int unsigned NSRC = 5,
  parameter int unsigned DW   = 8
) (
  input  logic [NSRC-1:0] flag_q,
  input  logic [NSRC-1:0] mask_q,
  input  logic            rd_sel,
  output logic            pending,
  output logic [DW-1:0]   rdata
);
  localparam int unsigned PAD_W = DW - 1 - NSRC;

  assign pending = |(flag_q & mask_q);

  always_comb begin
    rdata = '0;
    if (rd_sel) begin
      rdata[NSRC-1:0] = flag_q;
      rdata[DW-1]     = pending;
    end
  end

  // Elaboration guard: the flags and the summary bit must fit the bus
  if (DW < NSRC + 1) begin : g_bad_width
    initial $error("icr_status: DW too small for NSRC flags plus summary");
  end else if (PAD_W > 0) begin : g_pad
    // Padding bits are left at the zero default above
  end
endmodule

// File: rtl/icr_top.sv
module icr_top
  import icr_pkg::*;
#(
  parameter int unsigned NSRC = ICR_NSRC,
  parameter int unsigned DW   = ICR_DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_cs,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_evt,
  output logic            irq_n
);
  localparam int unsigned OP_BIT = DW - 1;

  logic            wr_sel;
  logic            rd_sel;
  mask_op_e        wr_op;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] flag_q;
  logic            pending;

  assign wr_sel = bus_cs && bus_wr;
  assign rd_sel = bus_cs && bus_rd;
  assign wr_op  = mask_op_e'(bus_wdata[OP_BIT]);

  if (OP_BIT > NSRC) begin : g_pad_in
    logic unused_wpad;
    assign unused_wpad = ^bus_wdata[OP_BIT-1:NSRC];
  end

  icr_mask_reg #(.NSRC(NSRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (wr_sel),
    .upd_op (wr_op),
    .upd_sel(bus_wdata[NSRC-1:0]),
    .mask_q (mask_q)
  );

  icr_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .ack   (rd_sel),
    .evt   (src_evt),
    .flag_q(flag_q)
  );

  icr_status #(.NSRC(NSRC), .DW(DW)) u_status (
    .flag_q (flag_q),
    .mask_q (mask_q),
    .rd_sel (rd_sel),
    .pending(pending),
    .rdata  (bus_rdata)
  );

  assign irq_n = !pending;
endmodule

// File: rtl/icr_chk.sv
module icr_chk #(
  parameter int unsigned NSRC = 5,
  parameter int unsigned DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_cs,
  input logic            bus_rd,
  input logic            bus_wr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic [NSRC-1:0] src_evt,
  input logic            irq_n,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] flag_q
);
  logic            rd_hit;
  logic            wr_hit;
  logic [NSRC-1:0] sel;

  assign rd_hit = bus_cs && bus_rd;
  assign wr_hit = bus_cs && bus_wr;
  assign sel    = bus_wdata[NSRC-1:0];

  if (DW - 1 > NSRC) begin : g_pad_chk
    logic unused_pad;
    assign unused_pad = ^bus_wdata[DW-2:NSRC];
    // R5
    rdata_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DW-2:NSRC] == '0);
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_n && mask_q == '0));

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && bus_wdata[DW-1]) |=> ((mask_q & $past(sel)) == $past(sel)));

  // R3
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !bus_wdata[DW-1]) |=> ((mask_q & $past(sel)) == '0));

  // R3
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((mask_q & ~$past(sel)) == ($past(mask_q) & ~$past(sel))));

  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(mask_q));

  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && src_evt == '0) |=> (irq_n && flag_q == '0));

  // R9
  event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> ((flag_q & $past(src_evt)) == $past(src_evt)));

  // R8
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !bus_cs) |=> !irq_n);

  // R5
  summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (bus_rdata[DW-1] == !irq_n));
endmodule

bind icr_top icr_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_cs   (bus_cs),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .src_evt  (src_evt),
  .irq_n    (irq_n),
  .mask_q   (mask_q),
  .flag_q   (flag_q)
);

// File: tb/icr_top_tb_top.sv
module icr_top_tb_top;
  localparam int NSRC = 5;
  localparam int DW   = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_cs = 1'b0;
  logic            bus_rd = 1'b0;
  logic            bus_wr = 1'b0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [DW-1:0]   bus_rdata;
  logic [NSRC-1:0] src_evt = '0;
  logic            irq_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;  // 250 MHz

  icr_top #(.NSRC(NSRC), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_evt(src_evt), .irq_n(irq_n)
  );

  // Monitor: compares read data against the scoreboard queue
  always begin
    @(negedge clk);
    #1;
    if (bus_cs && bus_rd) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL read with empty scoreboard: got %02h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (bus_rdata !== e.exp) begin
          errors++;
          $display("FAIL %s: rdata %02h expected %02h", e.tag, bus_rdata, e.exp);
        end
      end
    end
  end

  task automatic chk_irq(input logic exp, input string tag);
    #1;
    checks++;
    if (irq_n !== exp) begin
      errors++;
      $display("FAIL %s: irq_n %0b expected %0b", tag, irq_n, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [DW-1:0] v, input logic cs = 1'b1);
    @(negedge clk);
    bus_cs = cs; bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_cs = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  // Driver: pushes the expected read value, then performs the read
  task automatic rd_reg(input logic [DW-1:0] exp, input string tag,
                        input logic [NSRC-1:0] ev = '0);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    bus_cs = 1'b1; bus_rd = 1'b1; src_evt = ev;
    @(negedge clk);
    bus_cs = 1'b0; bus_rd = 1'b0; src_evt = '0;
  endtask

  task automatic pulse(input logic [NSRC-1:0] ev);
    @(negedge clk);
    src_evt = ev;
    @(negedge clk);
    src_evt = '0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    chk_irq(1'b1, "R1 idle after reset");
    rd_reg(8'h00, "R1 reset read");

    // Masked event latches, no request
    pulse(5'h01);
    chk_irq(1'b1, "R7 masked event keeps irq_n high");
    rd_reg(8'h01, "R7 masked flag still latched");
    rd_reg(8'h00, "R6 flags cleared by previous read");

    // Bit positions, one source at a time
    for (int i = 0; i < NSRC; i++) begin
      pulse(5'(1 << i));
      rd_reg(8'(1 << i), "R2 source bit position");
    end

    // Enable timers A and B
    wr_reg(8'h83);
    pulse(5'h02);
    chk_irq(1'b0, "R4 0x83 enables timer B");
    idle(6);
    chk_irq(1'b0, "R8 request held while pending");
    rd_reg(8'h82, "R5 summary with timer B");
    chk_irq(1'b1, "R6 read releases request");

    // Disable them again
    wr_reg(8'h03);
    pulse(5'h03);
    chk_irq(1'b1, "R4 0x03 disables timers");
    rd_reg(8'h03, "R4 flags without summary");

    // Selective updates: set alarm, set timer A, clear alarm
    wr_reg(8'h84);
    wr_reg(8'h81);
    wr_reg(8'h04);
    pulse(5'h04);
    chk_irq(1'b1, "R3 cleared bit stays disabled");
    pulse(5'h01);
    chk_irq(1'b0, "R3 unselected bit kept its set value");
    rd_reg(8'h85, "R3 read after selective updates");

    // Disable all, then enable a pending source
    wr_reg(8'h7F);
    pulse(5'h10);
    chk_irq(1'b1, "R4 0x7F disables all");
    wr_reg(8'h90);
    chk_irq(1'b0, "R7 enabling pending source asserts request");
    rd_reg(8'h90, "R7 external flag summary");

    // Event colliding with a read
    pulse(5'h10);
    rd_reg(8'h90, "R9 read during new event", 5'h08);
    chk_irq(1'b1, "R9 new serial flag is masked");
    rd_reg(8'h08, "R9 colliding event kept");

    // Strobes without chip select
    wr_reg(8'hFF, 1'b0);
    pulse(5'h08);
    chk_irq(1'b1, "R10 unselected write left mask alone");
    @(negedge clk); bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    rd_reg(8'h08, "R10 unselected read left flags");

    // All sources, padding bits
    wr_reg(8'hFF);
    pulse(5'h1F);
    chk_irq(1'b0, "R5 all enabled");
    rd_reg(8'h9F, "R5 padding bits read zero");
    chk_irq(1'b1, "R6 released after full read");

    idle(3);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d reads outstanding expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule